// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host-facing register front end of a network controller. The host cannot address the controller's many control/status registers (CSRs) and bus configuration registers (BCRs) directly. It first writes an 8-bit index into a pointer port. It then reads or writes through one of two data ports. The CSR data port and the BCR data port both use that one pointer, so the same index value picks entry N of whichever space the access goes to.

The block decodes I/O offsets for two bus widths. It holds the controller status word, whose event flags are cleared by writing ones and whose top bit is a read-only summary of those flags. It also holds an interrupt mask register, a missed-frame counter and a small bank of BCR storage. Event pulses from the MAC set the flags. A duplex input gates the collision-test flag, and a stop pulse clears that flag. The interrupt output is a plain function of the flags, the enable bit and the masks.

Top module: `nic_reg_access`

## Requirements
- R1: In word mode (`dword_mode`=0) the pointer port is at offset 12h, and in double-word mode it is at 14h. It stores write data bits 7:0, and a read returns the index in bits 7:0 with all higher bits zero. An access at the other mode's pointer offset has no effect.
- R2: Offset 10h is the CSR data port in both modes. It reaches the CSR whose index equals the current pointer value. Implemented CSRs are index 0 (status), index 3 (masks) and index 112 (missed-frame counter).
- R3: The BCR data port is at offset 16h in word mode and at 1Ch in double-word mode. It reaches BCR entry `ptr`. Entries 0 to N_BCR-1 are 16-bit read/write storage.
- R4: `rst` or `soft_rst` clears the pointer and all other state, and `intr` reads 0 after reset. A `stop_set` pulse leaves the pointer unchanged.
- R5: Status bit 15 reads as the OR of the flags in bits 13 (collision-test), 12 (missed frame) and 11 (memory error), and writes to it are ignored. Bit 14 always reads 0.
- R6: In a status write, a 1 in bit 13, 12 or 11 clears that flag and a 0 leaves it unchanged. Bit 6 is the interrupt enable and is plain read/write.
- R7: `ev_coll_fail` sets bit 13 only when `full_duplex`=0. A `stop_set` pulse clears bit 13. Bit 13 never drives `intr`.
- R8: Each `ev_miss` pulse sets bit 12 and adds one to the counter read at CSR index 112. Writes to that index are ignored.
- R9: `intr` = bit6 AND ((bit12 AND NOT mask bit12) OR (bit11 AND NOT mask bit11)), using the mask bits at CSR index 3. It follows one clock after the flag or register change.
- R10: Reads of any other CSR index, of a BCR index at or above N_BCR, or of an undecoded offset return 0. Writes there change no state.
- R11: When a set event and a clear (a write-one or a stop) hit a flag in the same cycle, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hardware reset, active high |
| soft_rst | input | 1 | Synchronous software reset, active high |
| dword_mode | input | 1 | 0 = word offsets, 1 = double-word offsets |
| io_addr | input | 5 | I/O byte offset |
| io_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| io_wr | input | 1 | Write strobe, taken at the clock edge |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data; zero when no read is in progress |
| full_duplex | input | 1 | Duplex mode; when 1, collision-test events are blocked |
| stop_set | input | 1 | Pulse marking that the stop bit was set |
| ev_coll_fail | input | 1 | Collision-test failure event pulse |
| ev_miss | input | 1 | Missed-frame event pulse |
| ev_mem_err | input | 1 | Memory error event pulse |
| intr | output | 1 | Interrupt request |

## Verification
A host write-one clear of a status flag can land in the same cycle as a MAC event that sets that flag. The same conflict arises between a stop pulse and a collision-test event. The bench forces both collisions with directed cycles that read the status word back and expect the flag to stay set. Random traffic mixes event pulses with CSR0 writes at a high rate, so the collision recurs many times, and each outcome is compared against a bench model in which set has priority.

// File: rtl/nic_reg_pkg.sv
package nic_reg_pkg;

    localparam int PTR_W  = 8;
    localparam int REG_W  = 16;
    localparam int DATA_W = 32;
    localparam int OFS_W  = 5;

    localparam logic [OFS_W-1:0] OFS_CSR    = 5'h10;
    localparam logic [OFS_W-1:0] OFS_PTR_WD = 5'h12;
    localparam logic [OFS_W-1:0] OFS_PTR_DW = 5'h14;
    localparam logic [OFS_W-1:0] OFS_BCR_WD = 5'h16;
    localparam logic [OFS_W-1:0] OFS_BCR_DW = 5'h1C;

    localparam logic [PTR_W-1:0] IDX_STAT = 8'd0;
    localparam logic [PTR_W-1:0] IDX_MASK = 8'd3;
    localparam logic [PTR_W-1:0] IDX_MCNT = 8'd112;

    localparam int B_ERR  = 15;
    localparam int B_RSV  = 14;
    localparam int B_CERR = 13;
    localparam int B_MISS = 12;
    localparam int B_MERR = 11;
    localparam int B_IEN  = 6;

    typedef enum logic [1:0] {
        PORT_NONE = 2'd0,
        PORT_CSR  = 2'd1,
        PORT_PTR  = 2'd2,
        PORT_BCR  = 2'd3
    } port_e;

    typedef struct packed {
        logic cerr;
        logic miss;
        logic merr;
    } flags_t;

    typedef struct packed {
        logic mask_miss;
        logic mask_merr;
        logic ien;
    } ctrl_t;

    function automatic port_e decode_port(input logic [OFS_W-1:0] ofs, input logic dw);
        port_e p;
        p = PORT_NONE;
        if (ofs == OFS_CSR)
            p = PORT_CSR;
        else if (ofs == (dw ? OFS_PTR_DW : OFS_PTR_WD))
            p = PORT_PTR;
        else if (ofs == (dw ? OFS_BCR_DW : OFS_BCR_WD))
            p = PORT_BCR;
        return p;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input flags_t f, input logic ien);
        logic [REG_W-1:0] w;
        w         = '0;
        w[B_ERR]  = f.cerr | f.miss | f.merr;
        w[B_RSV]  = 1'b0;
        w[B_CERR] = f.cerr;
        w[B_MISS] = f.miss;
        w[B_MERR] = f.merr;
        w[B_IEN]  = ien;
        return w;
    endfunction

endpackage

// File: rtl/nic_ptr_reg.sv
module nic_ptr_reg
    import nic_reg_pkg::*;
#(
    parameter int W = PTR_W
) (
    input  logic         clk,
    input  logic         rst_any,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ptr
);

    always_ff @(posedge clk) begin
        if (rst_any)
            ptr <= '0;
        else if (wr_en)
            ptr <= wdata;
    end

endmodule

// File: rtl/nic_status_unit.sv
module nic_status_unit
    import nic_reg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_any,
    input  logic             stop_set,
    input  logic             full_duplex,
    input  logic             ev_coll_fail,
    input  logic             ev_miss,
    input  logic             ev_mem_err,
    input  logic             wr_stat,
    input  logic             wr_mask,
    input  logic [REG_W-1:0] wdata,
    output flags_t           flags,
    output ctrl_t            ctrl,
    output logic [CNT_W-1:0] miss_cnt,
    output logic [REG_W-1:0] stat_word,
    output logic [REG_W-1:0] mask_word,
    output logic             intr
);

    localparam int NFLAG = 3;

    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] clr_v;
    logic [NFLAG-1:0] flag_q;
    logic             unused_wbits;

    assign unused_wbits = ^{wdata[15:14], wdata[10:7], wdata[5:0]};

    // index 2 = collision-test, 1 = missed frame, 0 = memory error
    assign set_v = {ev_coll_fail & ~full_duplex, ev_miss, ev_mem_err};
    assign clr_v = {(wr_stat & wdata[B_CERR]) | stop_set,
                    wr_stat & wdata[B_MISS],
                    wr_stat & wdata[B_MERR]};

    for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst_any)
                flag_q[gi] <= 1'b0;
            else if (set_v[gi])
                flag_q[gi] <= 1'b1;
            else if (clr_v[gi])
                flag_q[gi] <= 1'b0;
        end
    end

    assign flags = flag_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            ctrl <= '0;
        end else begin
            if (wr_stat)
                ctrl.ien <= wdata[B_IEN];
            if (wr_mask) begin
                ctrl.mask_miss <= wdata[B_MISS];
                ctrl.mask_merr <= wdata[B_MERR];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst_any)
            miss_cnt <= '0;
        else if (ev_miss)
            miss_cnt <= miss_cnt + CNT_W'(1);
    end

    always_comb begin
        stat_word = pack_status(flags, ctrl.ien);
        mask_word = '0;
        mask_word[B_MISS] = ctrl.mask_miss;
        mask_word[B_MERR] = ctrl.mask_merr;
    end

    assign intr = ctrl.ien & ((flags.miss & ~ctrl.mask_miss) |
                              (flags.merr & ~ctrl.mask_merr));

endmodule

// File: rtl/nic_bcr_bank.sv
module nic_bcr_bank
    import nic_reg_pkg::*;
#(
    parameter int N_BCR = 4,
    parameter int W     = REG_W
) (
    input  logic             clk,
    input  logic             rst_any,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] idx,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     rdata
);

    logic [W-1:0] regs [N_BCR];

    for (genvar gi = 0; gi < N_BCR; gi++) begin : g_bcr
        always_ff @(posedge clk) begin
            if (rst_any)
                regs[gi] <= '0;
            else if (wr_en && idx == PTR_W'(gi))
                regs[gi] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_BCR; i++)
            if (idx == PTR_W'(i))
                rdata = regs[i];
    end

endmodule

// File: rtl/nic_reg_access.sv
module nic_reg_access
    import nic_reg_pkg::*;
#(
    parameter int N_BCR = 4,
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              dword_mode,
    input  logic [OFS_W-1:0]  io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              full_duplex,
    input  logic              stop_set,
    input  logic              ev_coll_fail,
    input  logic              ev_miss,
    input  logic              ev_mem_err,
    output logic              intr
);

    port_e             port_sel;
    logic              rst_any;
    logic [PTR_W-1:0]  ptr_q;
    flags_t            flags_q;
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  miss_cnt;
    logic [REG_W-1:0]  stat_word;
    logic [REG_W-1:0]  mask_word;
    logic [REG_W-1:0]  bcr_rd;
    logic [REG_W-1:0]  csr_rd;
    logic [REG_W-1:0]  cnt_word;
    logic              wr_ptr, wr_csr, wr_bcr;
    logic              unused_hi;

    assign unused_hi = ^io_wdata[DATA_W-1:REG_W];

    assign port_sel = decode_port(io_addr, dword_mode);
    assign rst_any  = rst | soft_rst;
    assign wr_ptr   = io_wr && (port_sel == PORT_PTR);
    assign wr_csr   = io_wr && (port_sel == PORT_CSR);
    assign wr_bcr   = io_wr && (port_sel == PORT_BCR);

    nic_ptr_reg #(.W(PTR_W)) u_ptr (
        .clk     (clk),
        .rst_any (rst_any),
        .wr_en   (wr_ptr),
        .wdata   (io_wdata[PTR_W-1:0]),
        .ptr     (ptr_q)
    );

    nic_status_unit #(.CNT_W(CNT_W)) u_stat (
        .clk          (clk),
        .rst_any      (rst_any),
        .stop_set     (stop_set),
        .full_duplex  (full_duplex),
        .ev_coll_fail (ev_coll_fail),
        .ev_miss      (ev_miss),
        .ev_mem_err   (ev_mem_err),
        .wr_stat      (wr_csr && (ptr_q == IDX_STAT)),
        .wr_mask      (wr_csr && (ptr_q == IDX_MASK)),
        .wdata        (io_wdata[REG_W-1:0]),
        .flags        (flags_q),
        .ctrl         (ctrl_q),
        .miss_cnt     (miss_cnt),
        .stat_word    (stat_word),
        .mask_word    (mask_word),
        .intr         (intr)
    );

    nic_bcr_bank #(.N_BCR(N_BCR), .W(REG_W)) u_bcr (
        .clk     (clk),
        .rst_any (rst_any),
        .wr_en   (wr_bcr),
        .idx     (ptr_q),
        .wdata   (io_wdata[REG_W-1:0]),
        .rdata   (bcr_rd)
    );

    always_comb begin
        cnt_word = '0;
        cnt_word[CNT_W-1:0] = miss_cnt;
        unique case (ptr_q)
            IDX_STAT: csr_rd = stat_word;
            IDX_MASK: csr_rd = mask_word;
            IDX_MCNT: csr_rd = cnt_word;
            default:  csr_rd = '0;
        endcase
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            unique case (port_sel)
                PORT_PTR: io_rdata[PTR_W-1:0] = ptr_q;
                PORT_CSR: io_rdata[REG_W-1:0] = csr_rd;
                PORT_BCR: io_rdata[REG_W-1:0] = bcr_rd;
                default:  io_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/nic_reg_access_chk.sv
module nic_reg_access_chk
    import nic_reg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              io_rd,
    input logic              io_wr,
    input port_e             port_sel,
    input logic [PTR_W-1:0]  ptr_q,
    input flags_t            flags_q,
    input ctrl_t             ctrl_q,
    input logic [CNT_W-1:0]  miss_cnt,
    input logic [DATA_W-1:0] io_rdata,
    input logic              full_duplex,
    input logic              stop_set,
    input logic              ev_miss,
    input logic              intr
);

    assert_ptr_stop_R4: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (stop_set && !(io_wr && port_sel == PORT_PTR)) |=> ptr_q == $past(ptr_q));

    assert_err_sum_R5: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (io_rd && port_sel == PORT_CSR && ptr_q == IDX_STAT) |->
        (io_rdata[B_ERR] == (|io_rdata[B_CERR:B_MERR])) && !io_rdata[B_RSV]);

    assert_cerr_fdx_R7: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (full_duplex && !flags_q.cerr) |=> !flags_q.cerr);

    assert_cnt_step_R8: assert property (@(posedge clk) disable iff (rst || soft_rst)
        ev_miss |=> miss_cnt == $past(miss_cnt) + CNT_W'(1));

    assert_miss_wins_R11: assert property (@(posedge clk) disable iff (rst || soft_rst)
        ev_miss |=> flags_q.miss);

    assert_intr_gate_R9: assert property (@(posedge clk) disable iff (rst || soft_rst)
        !ctrl_q.ien |-> !intr);

    assert_unmapped_R10: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (io_rd && port_sel == PORT_CSR && ptr_q != IDX_STAT && ptr_q != IDX_MASK &&
         ptr_q != IDX_MCNT) |-> io_rdata == '0);

    assert_ptr_upper_R1: assert property (@(posedge clk) disable iff (rst || soft_rst)
        (io_rd && port_sel == PORT_PTR) |-> io_rdata[DATA_W-1:PTR_W] == '0);

endmodule

bind nic_reg_access nic_reg_access_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .soft_rst    (soft_rst),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .port_sel    (port_sel),
    .ptr_q       (ptr_q),
    .flags_q     (flags_q),
    .ctrl_q      (ctrl_q),
    .miss_cnt    (miss_cnt),
    .io_rdata    (io_rdata),
    .full_duplex (full_duplex),
    .stop_set    (stop_set),
    .ev_miss     (ev_miss),
    .intr        (intr)
);

// File: tb/nic_reg_access_tb_top.sv
`timescale 1ns/1ps
module nic_reg_access_tb_top;

    localparam int NB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_rst = 1'b0;
    logic        dword_mode = 1'b0;
    logic [4:0]  io_addr = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        full_duplex = 1'b0;
    logic        stop_set = 1'b0;
    logic        ev_coll_fail = 1'b0;
    logic        ev_miss = 1'b0;
    logic        ev_mem_err = 1'b0;
    logic        intr;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model
    logic [7:0]  m_ptr;
    logic        m_cerr, m_miss, m_merr, m_ien, m_mk_miss, m_mk_merr;
    logic [15:0] m_cnt;
    logic [15:0] m_bcr [NB];

    always #2.5 clk = ~clk;

    nic_reg_access #(.N_BCR(NB), .CNT_W(16)) dut_i (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .dword_mode(dword_mode),
        .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata),
        .io_rdata(io_rdata), .full_duplex(full_duplex), .stop_set(stop_set),
        .ev_coll_fail(ev_coll_fail), .ev_miss(ev_miss), .ev_mem_err(ev_mem_err),
        .intr(intr)
    );

    // 0 none, 1 CSR data, 2 pointer, 3 BCR data
    function automatic int which_port(logic [4:0] a, logic dw);
        if (a == 5'h10) return 1;
        if (!dw && a == 5'h12) return 2;
        if (dw && a == 5'h14) return 2;
        if (!dw && a == 5'h16) return 3;
        if (dw && a == 5'h1C) return 3;
        return 0;
    endfunction

    function automatic logic [31:0] exp_read(logic [4:0] a, logic dw);
        logic [31:0] v;
        v = '0;
        case (which_port(a, dw))
            1: begin
                if (m_ptr == 8'd0) begin
                    v[15] = m_cerr | m_miss | m_merr;
                    v[13] = m_cerr; v[12] = m_miss; v[11] = m_merr; v[6] = m_ien;
                end else if (m_ptr == 8'd3) begin
                    v[12] = m_mk_miss; v[11] = m_mk_merr;
                end else if (m_ptr == 8'd112) begin
                    v[15:0] = m_cnt;
                end
            end
            2: v[7:0] = m_ptr;
            3: if (m_ptr < NB) v[15:0] = m_bcr[m_ptr[1:0]];
            default: v = '0;
        endcase
        return v;
    endfunction

    function automatic logic exp_intr();
        return m_ien & ((m_miss & ~m_mk_miss) | (m_merr & ~m_mk_merr));
    endfunction

    task automatic model_reset();
        m_ptr = '0; m_cerr = 0; m_miss = 0; m_merr = 0; m_ien = 0;
        m_mk_miss = 0; m_mk_merr = 0; m_cnt = '0;
        for (int i = 0; i < NB; i++) m_bcr[i] = '0;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step(logic wr, logic [4:0] a, logic dw, logic [31:0] wd,
                              logic ec, logic em, logic ee, logic st, logic sr, logic fd);
        logic c_clr, m_clr, e_clr;
        int p;
        if (sr) begin
            model_reset();
            return;
        end
        p = which_port(a, dw);
        c_clr = st; m_clr = 0; e_clr = 0;
        if (wr && p == 2) m_ptr = wd[7:0];
        if (wr && p == 1 && m_ptr == 8'd0) begin
            c_clr = c_clr | wd[13]; m_clr = wd[12]; e_clr = wd[11];
            m_ien = wd[6];
        end
        if (wr && p == 1 && m_ptr == 8'd3) begin
            m_mk_miss = wd[12]; m_mk_merr = wd[11];
        end
        if (wr && p == 3 && m_ptr < NB) m_bcr[m_ptr[1:0]] = wd[15:0];
        m_cerr = (ec && !fd) ? 1'b1 : (c_clr ? 1'b0 : m_cerr);
        m_miss = em ? 1'b1 : (m_clr ? 1'b0 : m_miss);
        m_merr = ee ? 1'b1 : (e_clr ? 1'b0 : m_merr);
        if (em) m_cnt = m_cnt + 16'd1;
    endtask

    // one bus cycle: drive at negedge, check read data before the edge, intr after
    task automatic cycle(logic wr, logic rd, logic [4:0] a, logic [31:0] wd,
                         logic ec, logic em, logic ee, logic st, logic sr, string req);
        @(negedge clk);
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = wd;
        ev_coll_fail = ec; ev_miss = em; ev_mem_err = ee; stop_set = st; soft_rst = sr;
        #1;
        if (rd) check(req, io_rdata, exp_read(a, dword_mode));
        @(posedge clk);
        model_step(wr, a, dword_mode, wd, ec, em, ee, st, sr, full_duplex);
        #1;
        check("R9", {31'd0, intr}, {31'd0, exp_intr()});
    endtask

    task automatic wr_ptr(logic [7:0] v);
        cycle(1, 0, dword_mode ? 5'h14 : 5'h12, {24'd0, v}, 0, 0, 0, 0, 0, "R1");
    endtask
    task automatic rd_at(logic [4:0] a, string req);
        cycle(0, 1, a, '0, 0, 0, 0, 0, 0, req);
    endtask
    task automatic wr_at(logic [4:0] a, logic [31:0] d, string req);
        cycle(1, 0, a, d, 0, 0, 0, 0, 0, req);
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [4:0] addrs [6];
        logic [7:0] idxs [7];
        addrs = '{5'h10, 5'h12, 5'h14, 5'h16, 5'h1C, 5'h08};
        idxs  = '{8'd0, 8'd3, 8'd112, 8'd1, 8'd2, 8'd5, 8'd200};
        model_reset();
        void'($urandom(32'h5eed1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R4: reset state
        rd_at(5'h12, "R4");
        rd_at(5'h10, "R4");
        check("R4", {31'd0, intr}, 32'd0);

        // R1: pointer holds bits 7:0, upper zero, word offset
        wr_ptr(8'hB5);
        cycle(1, 0, 5'h12, 32'hFFFF_1AB5, 0, 0, 0, 0, 0, "R1");
        rd_at(5'h12, "R1");
        // R1: 14h in word mode is not the pointer
        wr_at(5'h14, 32'h0000_0077, "R1");
        rd_at(5'h12, "R1");
        dword_mode = 1'b1;
        cycle(1, 0, 5'h14, 32'hFFFF_FF03, 0, 0, 0, 0, 0, "R1");
        rd_at(5'h14, "R1");
        wr_at(5'h12, 32'h0000_0055, "R1");
        rd_at(5'h14, "R1");

        // R3: BCR port at 1Ch (dword) and 16h (word), shared pointer
        wr_ptr(8'd2);
        wr_at(5'h1C, 32'h0000_BEEF, "R3");
        rd_at(5'h1C, "R3");
        rd_at(5'h16, "R10");
        dword_mode = 1'b0;
        rd_at(5'h16, "R3");
        wr_at(5'h1C, 32'h0000_1111, "R10");
        rd_at(5'h16, "R3");

        // R2/R6/R9: enable interrupt, set miss, clear by write-one
        wr_ptr(8'd0);
        wr_at(5'h10, 32'h0000_0040, "R6");
        cycle(0, 0, 5'h00, '0, 0, 1, 0, 0, 0, "R8");
        rd_at(5'h10, "R2");
        wr_at(5'h10, 32'h0000_0040, "R6");
        rd_at(5'h10, "R6");
        wr_at(5'h10, 32'h0000_1040, "R6");
        rd_at(5'h10, "R6");

        // R5: write to bit 15/14 ignored
        cycle(0, 0, 5'h00, '0, 0, 0, 1, 0, 0, "R5");
        wr_at(5'h10, 32'h0000_C040, "R5");
        rd_at(5'h10, "R5");

        // R9: mask hides memory error
        wr_ptr(8'd3);
        wr_at(5'h10, 32'h0000_0800, "R9");
        rd_at(5'h10, "R9");
        wr_at(5'h10, 32'h0000_0000, "R9");

        // R7: collision flag gated by duplex, cleared by stop, no intr
        wr_ptr(8'd0);
        wr_at(5'h10, 32'h0000_0840, "R6");
        full_duplex = 1'b1;
        cycle(0, 0, 5'h00, '0, 1, 0, 0, 0, 0, "R7");
        rd_at(5'h10, "R7");
        full_duplex = 1'b0;
        cycle(0, 0, 5'h00, '0, 1, 0, 0, 0, 0, "R7");
        rd_at(5'h10, "R7");
        check("R7", {31'd0, intr}, 32'd0);
        cycle(0, 0, 5'h00, '0, 0, 0, 0, 1, 0, "R4");
        rd_at(5'h10, "R7");
        rd_at(5'h12, "R4");

        // R11: set and clear in the same cycle
        cycle(1, 0, 5'h10, 32'h0000_3840, 0, 1, 0, 0, 0, "R11");
        rd_at(5'h10, "R11");
        cycle(0, 0, 5'h00, '0, 1, 0, 0, 1, 0, "R11");
        rd_at(5'h10, "R11");

        // R8: counter at 112, writes ignored
        wr_ptr(8'd112);
        rd_at(5'h10, "R8");
        wr_at(5'h10, 32'h0000_ABCD, "R8");
        rd_at(5'h10, "R8");

        // R10: unimplemented CSR and BCR index
        wr_ptr(8'd77);
        wr_at(5'h10, 32'h0000_FFFF, "R10");
        rd_at(5'h10, "R10");
        rd_at(5'h16, "R10");
        rd_at(5'h08, "R10");

        // R4: soft reset clears pointer
        cycle(0, 0, 5'h00, '0, 0, 0, 0, 0, 1, "R4");
        rd_at(5'h12, "R4");

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [4:0]  a;
            logic [31:0] d;
            logic        w, r;
            string       tag;
            int          p;
            if ($urandom_range(0, 40) == 0) dword_mode = ~dword_mode;
            if ($urandom_range(0, 30) == 0) full_duplex = ~full_duplex;
            a = addrs[$urandom_range(0, 5)];
            w = ($urandom_range(0, 2) == 0);
            r = !w && ($urandom_range(0, 1) == 0);
            d = $urandom();
            p = which_port(a, dword_mode);
            if (w && p == 2) d[7:0] = ($urandom_range(0, 3) == 0) ? d[7:0] : idxs[$urandom_range(0, 6)];
            tag = (p == 1) ? "R2" : (p == 2) ? "R1" : (p == 3) ? "R3" : "R10";
            cycle(w, r, a, d,
                  $urandom_range(0, 6) == 0, $urandom_range(0, 5) == 0,
                  $urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0,
                  $urandom_range(0, 400) == 0, tag);
        end

        @(negedge clk);
        io_wr = 0; io_rd = 0; ev_coll_fail = 0; ev_miss = 0; ev_mem_err = 0;
        stop_set = 0; soft_rst = 0;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule